// File: doc/BRIEF.md
# MOVX Data-Memory Access Router

This block sits between an 8051-style core and two data stores: the on-chip expanded RAM array and an external multiplexed memory bus. Each external-data-move request carries a direction, an addressing mode (8-bit register-indirect or 16-bit data-pointer), a 16-bit address and write data. From these and three configuration inputs, the router decides where the access goes.

The first configuration input forces every access onto the external bus. The second is a two-bit field that sets how much of the on-chip array is visible. The third stretches the external strobe from 6 to 30 clocks. Internal accesses drive a synchronous RAM port and finish one clock after acceptance, and they leave the bus pins quiet. External accesses run a fixed sequence: an address-latch pulse, then a read or write strobe, then a one-clock completion.

The request side follows valid/ready rules. A request is taken on the edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the router is idle, so the core must hold its request and its configuration until that edge. The response is a one-clock `rsp_valid` pulse with no back-pressure, and the core must take it in that cycle.

Top module: `movx_router`

## Requirements
- R1: With the force-external input at 0, an 8-bit register-indirect access goes to the RAM port at address {00, req_addr[7:0]}, whatever req_addr[15:8] holds. It completes with rsp_valid one clock after acceptance. During that clock ale stays 0, rd_n and wr_n stay 1, p0_oe stays 0, and p0_out and p2_out keep their values.
- R2: With the force-external input at 0, a data-pointer access below the visible limit goes to the RAM port at address req_addr[9:0], and reads return the stored byte.
- R3: The visible limit is (cfg_xram_size + 1) * 256 bytes, giving 256, 512, 768 or 1024 for codes 00, 01, 10 and 11. A data-pointer access at or above the limit runs an external cycle.
- R4: With cfg_force_ext at 1, every access runs an external cycle, whatever the mode or address, and the RAM port stays disabled.
- R5: An external cycle starts with ale high for 2 clocks while p0_out drives req_addr[7:0] with p0_oe at 1. In data-pointer mode, p2_out shows req_addr[15:8] from the first of those clocks onward.
- R6: An external register-indirect cycle leaves p2_out at its previous value. After reset that value is 0xFF.
- R7: A read holds rd_n low with p0_oe at 0. The byte on p0_in in the last strobe clock is returned on rsp_rdata. A write holds wr_n low with p0_out driving the write data and p0_oe at 1. rd_n and wr_n are never low together.
- R8: The strobe lasts 6 clocks when cfg_stretch is 0 and 30 clocks when it is 1. rsp_valid rises in the clock after the strobe ends, which is acceptance plus strobe length plus 3.
- R9: req_ready is high only when the router is idle, and it returns high in the clock after rsp_valid. rsp_valid is high for exactly one clock per accepted request.
- R10: While reset is applied, req_ready=1, rsp_valid=0, ram_en=0, ale=0, rd_n=1, wr_n=1, p0_oe=0, p0_out=0xFF and p2_out=0xFF.
- R11: The configuration inputs and request fields are captured at acceptance. Changing them while an access is in progress does not alter its routing, strobe length, address or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dptr | input | 1 | 1 = 16-bit data-pointer mode, 0 = 8-bit register-indirect |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| cfg_force_ext | input | 1 | Send every access to the external bus |
| cfg_xram_size | input | 2 | Visible on-chip size code |
| cfg_stretch | input | 1 | Long (30-clock) strobe when 1 |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid on reads |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM port write enable |
| ram_addr | output | 10 | RAM port address |
| ram_wdata | output | 8 | RAM port write data |
| ram_rdata | input | 8 | RAM port read data, one clock after ram_en |
| p0_in | input | 8 | Low bus port input |
| p0_out | output | 8 | Low bus port output (address, then data) |
| p0_oe | output | 1 | Low bus port drive enable |
| p2_out | output | 8 | High address port |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The hardest situation to reach is a register-indirect external access that has to leave a page value on the high port, set earlier by a different kind of access. The stimulus sets up that state on purpose. It first runs a data-pointer external write to plant a known high byte, then runs an 8-bit access under forced-external mode, and finally runs an internal access to confirm that the bus stayed quiet and the page was kept. In every access, the bench also scrambles the configuration and address inputs right after acceptance, which shows that the router works only from the captured values.

// File: rtl/movx_pkg.sv
package movx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT,
    ST_ALE,
    ST_STRB,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic write;
    logic dptr;
    logic stretch;
  } acc_ctl_t;

endpackage

// File: rtl/movx_route.sv
module movx_route #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int XRAM_AW = 10,
  parameter int PAGE_W  = 8,
  parameter int SIZE_W  = 2
) (
  input  logic               force_ext,
  input  logic [SIZE_W-1:0]  size_code,
  input  logic               dptr,
  input  logic [ADDR_W-1:0]  addr,
  output logic               to_int,
  output logic [XRAM_AW-1:0] ram_addr
);
  localparam int LIM_W = ADDR_W + 1;

  logic [LIM_W-1:0] limit;
  logic             below_limit;

  // visible window grows in whole pages: (code + 1) pages
  assign limit       = (LIM_W'(size_code) + LIM_W'(1)) << PAGE_W;
  assign below_limit = ({1'b0, addr} < limit);

  // 8-bit indirect addresses always fall inside the first page
  assign to_int   = !force_ext && (!dptr || below_limit);
  assign ram_addr = dptr ? addr[XRAM_AW-1:0] : XRAM_AW'(addr[DATA_W-1:0]);
endmodule

// File: rtl/movx_phase_timer.sv
module movx_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/movx_bus_seq.sv
module movx_bus_seq
  import movx_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ALE_CYC    = 2,
  parameter int STRB_SHORT = 6,
  parameter int STRB_LONG  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              acc_int,
  input  acc_ctl_t          acc_ctl,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] p0_in,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              idle,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p2_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int MAXV  = (STRB_LONG > STRB_SHORT) ?
                         ((STRB_LONG > ALE_CYC) ? STRB_LONG : ALE_CYC) :
                         ((STRB_SHORT > ALE_CYC) ? STRB_SHORT : ALE_CYC);
  localparam int CNT_W = $clog2(MAXV + 1);

  seq_state_t        state_q;
  acc_ctl_t          ctl_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, p0_q, p2_q;
  logic              t_last, t_load;
  logic [CNT_W-1:0]  t_val;
  logic              strb_active;

  always_comb begin
    t_load = 1'b0;
    t_val  = CNT_W'(ALE_CYC - 1);
    if (state_q == ST_IDLE && accept && !acc_int) begin
      t_load = 1'b1;
    end else if (state_q == ST_ALE && t_last) begin
      t_load = 1'b1;
      t_val  = ctl_q.stretch ? CNT_W'(STRB_LONG - 1) : CNT_W'(STRB_SHORT - 1);
    end
  end

  movx_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      p0_q    <= '1;
      p2_q    <= '1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (acc_int) begin
            state_q <= ST_INT;
          end else begin
            state_q <= ST_ALE;
            ctl_q   <= acc_ctl;
            wdata_q <= acc_wdata;
            p0_q    <= acc_addr[DATA_W-1:0];
            if (acc_ctl.dptr) p2_q <= acc_addr[ADDR_W-1:ADDR_W-DATA_W];
          end
        end
        ST_ALE: if (t_last) begin
          state_q <= ST_STRB;
          if (ctl_q.write) p0_q <= wdata_q;
        end
        ST_STRB: if (t_last) begin
          state_q <= ST_DONE;
          if (!ctl_q.write) rdata_q <= p0_in;
        end
        ST_INT:  state_q <= ST_IDLE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign strb_active = (state_q == ST_STRB);
  assign idle        = (state_q == ST_IDLE);
  assign ale         = (state_q == ST_ALE);
  assign p0_oe       = ale || (strb_active && ctl_q.write);
  assign rd_n        = !(strb_active && !ctl_q.write);
  assign wr_n        = !(strb_active && ctl_q.write);
  assign rsp_valid   = (state_q == ST_INT) || (state_q == ST_DONE);
  assign rsp_rdata   = (state_q == ST_INT) ? ram_rdata : rdata_q;
  assign p0_out      = p0_q;
  assign p2_out      = p2_q;

  // checker state: length of the current run of an asserted strobe
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              low_run_q <= '0;
    else if (!(rd_n && wr_n)) low_run_q <= low_run_q + (CNT_W+1)'(1);
    else                     low_run_q <= '0;
  end

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r8_strobe_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n && wr_n) |->
      (low_run_q == (ctl_q.stretch ? (CNT_W+1)'(STRB_LONG) : (CNT_W+1)'(STRB_SHORT))));

  a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && state_q != ST_INT && !ctl_q.dptr) |-> $stable(p2_out));

  a_r1_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INT) |-> (!ale && rd_n && wr_n && !p0_oe && $stable(p0_out) && $stable(p2_out)));
endmodule

// File: rtl/movx_router.sv
module movx_router
  import movx_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XRAM_AW    = 10,
  parameter int PAGE_W     = 8,
  parameter int SIZE_W     = 2,
  parameter int ALE_CYC    = 2,
  parameter int STRB_SHORT = 6,
  parameter int STRB_LONG  = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_dptr,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               cfg_force_ext,
  input  logic [SIZE_W-1:0]  cfg_xram_size,
  input  logic               cfg_stretch,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               ram_en,
  output logic               ram_we,
  output logic [XRAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  input  logic [DATA_W-1:0]  p0_in,
  output logic [DATA_W-1:0]  p0_out,
  output logic               p0_oe,
  output logic [DATA_W-1:0]  p2_out,
  output logic               ale,
  output logic               rd_n,
  output logic               wr_n
);
  logic     idle, accept, to_int;
  acc_ctl_t ctl;

  movx_route #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XRAM_AW(XRAM_AW),
    .PAGE_W(PAGE_W), .SIZE_W(SIZE_W)
  ) u_route (
    .force_ext (cfg_force_ext),
    .size_code (cfg_xram_size),
    .dptr      (req_dptr),
    .addr      (req_addr),
    .to_int    (to_int),
    .ram_addr  (ram_addr)
  );

  assign req_ready   = idle;
  assign accept      = req_valid && idle;
  assign ctl.write   = req_write;
  assign ctl.dptr    = req_dptr;
  assign ctl.stretch = cfg_stretch;
  assign ram_en      = accept && to_int;
  assign ram_we      = req_write;
  assign ram_wdata   = req_wdata;

  movx_bus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALE_CYC(ALE_CYC),
    .STRB_SHORT(STRB_SHORT), .STRB_LONG(STRB_LONG)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .acc_int   (to_int),
    .acc_ctl   (ctl),
    .acc_addr  (req_addr),
    .acc_wdata (req_wdata),
    .p0_in     (p0_in),
    .ram_rdata (ram_rdata),
    .idle      (idle),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .p0_out    (p0_out),
    .p0_oe     (p0_oe),
    .p2_out    (p2_out),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );

  a_r4_forced_external: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_force_ext) |=> !rsp_valid);

  a_r4_ram_off_when_forced: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force_ext |-> !ram_en);

  a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/movx_router_tb.sv
module movx_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_dptr;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        cfg_force_ext, cfg_stretch;
  logic [1:0]  cfg_xram_size;
  logic        req_ready, rsp_valid, ram_en, ram_we, p0_oe, ale, rd_n, wr_n;
  logic [7:0]  rsp_rdata, ram_wdata, p0_out, p2_out, p0_in;
  logic [7:0]  ram_rdata;
  logic [9:0]  ram_addr;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [7:0] xram   [1024];
  logic [7:0] shadow [1024];
  int p2_exp = 8'hFF;
  int p0_last = 8'hFF;

  always #4 clk = ~clk;

  movx_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dptr(req_dptr), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_force_ext(cfg_force_ext),
    .cfg_xram_size(cfg_xram_size), .cfg_stretch(cfg_stretch),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // synchronous on-chip RAM model
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) xram[ram_addr] <= ram_wdata;
      ram_rdata <= xram[ram_addr];
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic pins(input string req, input int e_ale, input int e_rdn, input int e_wrn,
                      input int e_oe, input int e_p0, input int e_ready, input int e_rsp);
    chk(req, "ale", ale, e_ale);
    chk(req, "rd_n", rd_n, e_rdn);
    chk(req, "wr_n", wr_n, e_wrn);
    chk(req, "p0_oe", p0_oe, e_oe);
    if (e_p0 >= 0) chk(req, "p0_out", p0_out, e_p0);
    chk(req, "p2_out", p2_out, p2_exp);
    chk(req, "req_ready", req_ready, e_ready);
    chk(req, "rsp_valid", rsp_valid, e_rsp);
    chk(req, "ram_en", ram_en, 0);
  endtask

  task automatic access(input string req, input bit w, input bit d, input logic [15:0] a,
                        input logic [7:0] wd, input bit fe, input logic [1:0] sz,
                        input bit st, input logic [7:0] ext_rd);
    int lim = (int'(sz) + 1) * 256;
    bit internal = !fe && (!d || int'(a) < lim);
    int ia = d ? int'(a[9:0]) : int'(a[7:0]);
    int n = st ? 30 : 6;
    @(negedge clk);
    req_valid = 1; req_write = w; req_dptr = d; req_addr = a; req_wdata = wd;
    cfg_force_ext = fe; cfg_xram_size = sz; cfg_stretch = st; p0_in = ext_rd;
    #1;
    chk({req, "/R9"}, "req_ready", req_ready, 1);
    chk(req, "ram_en", ram_en, internal);
    if (internal) begin
      chk(req, "ram_addr", ram_addr, ia);
      chk(req, "ram_we", ram_we, w);
    end
    @(negedge clk);
    // R11: scramble everything after acceptance
    req_valid = 0; req_addr = ~a; req_wdata = ~wd; req_dptr = ~d; req_write = ~w;
    cfg_force_ext = ~fe; cfg_xram_size = ~sz; cfg_stretch = ~st;
    #1;
    if (internal) begin
      pins({req, "/R1"}, 0, 1, 1, 0, p0_last, 0, 1);
      if (!w) chk(req, "rsp_rdata", rsp_rdata, shadow[ia]);
      else shadow[ia] = wd;
    end else begin
      if (d) p2_exp = a[15:8];
      for (int c = 0; c < 2; c++) begin
        if (c > 0) begin @(negedge clk); #1; end
        pins({req, "/R5"}, 1, 1, 1, 1, a[7:0], 0, 0);
      end
      for (int c = 0; c < n; c++) begin
        @(negedge clk); #1;
        pins({req, "/R7/R8"}, 0, w, !w, w, w ? wd : -1, 0, 0);
      end
      @(negedge clk); #1;
      pins({req, "/R8"}, 0, 1, 1, 0, -1, 0, 1);
      if (!w) chk({req, "/R7"}, "rsp_rdata", rsp_rdata, ext_rd);
      p0_last = w ? wd : a[7:0];
    end
    @(negedge clk); #1;
    chk({req, "/R9"}, "req_ready", req_ready, 1);
    chk({req, "/R9"}, "rsp_valid", rsp_valid, 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_dptr = 0; req_addr = 0;
    req_wdata = 0; cfg_force_ext = 0; cfg_xram_size = 0; cfg_stretch = 0; p0_in = 0;
    for (int i = 0; i < 1024; i++) begin xram[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "req_ready", req_ready, 1);
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "ram_en", ram_en, 0);
    chk("R10", "ale", ale, 0);
    chk("R10", "rd_n", rd_n, 1);
    chk("R10", "wr_n", wr_n, 1);
    chk("R10", "p0_oe", p0_oe, 0);
    chk("R10", "p0_out", p0_out, 8'hFF);
    chk("R10", "p2_out", p2_out, 8'hFF);
    rst_n = 1;

    access("R1 ri_wr",      1, 0, 16'hFF34, 8'hA5, 0, 2'd0, 0, 8'h00);
    access("R1 ri_rd",      0, 0, 16'h0034, 8'h00, 0, 2'd0, 0, 8'h00);
    access("R2 dp_wr2ff",   1, 1, 16'h02FF, 8'h3C, 0, 2'd2, 0, 8'h00);
    access("R2 dp_rd2ff",   0, 1, 16'h02FF, 8'h00, 0, 2'd2, 0, 8'h00);
    access("R3 dp_rd300",   0, 1, 16'h0300, 8'h00, 0, 2'd2, 0, 8'h77);
    access("R3 dp_wr3ff",   1, 1, 16'h03FF, 8'h11, 0, 2'd3, 1, 8'h00);
    access("R3 dp_rd3ff",   0, 1, 16'h03FF, 8'h00, 0, 2'd3, 0, 8'h00);
    access("R3 dp_rd100",   0, 1, 16'h0100, 8'h00, 0, 2'd0, 0, 8'h42);
    access("R4 ri_rd_ext",  0, 0, 16'h0034, 8'h00, 1, 2'd3, 0, 8'h99);
    access("R8 dp_wr_long", 1, 1, 16'hABCD, 8'h5E, 1, 2'd3, 1, 8'h00);
    access("R6 ri_wr_page", 1, 0, 16'h1255, 8'hC3, 1, 2'd0, 1, 8'h00);
    access("R6 ri_rd_page", 0, 0, 16'h0010, 8'h00, 1, 2'd1, 0, 8'h6B);
    access("R1 ri_rd_back", 0, 0, 16'h0034, 8'h00, 0, 2'd0, 0, 8'h00);
    access("R3 dp_rd400",   0, 1, 16'h0400, 8'h00, 0, 2'd3, 0, 8'h24);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule